// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core whose visible register set changes with the operating mode. A 5-bit mode input chooses, for each of the sixteen architectural indices, which physical copy is seen. The low eight indices and the program counter slot (index 15) are always shared. Indices 8 to 12 get a private copy in the fast-interrupt mode. The stack and link slots (indices 13 and 14) get a private copy in every exception mode. In total it stores 31 general registers, one current status register and five saved status registers. The program counter is stored here like any other register and is not incremented.

Two read ports are combinational. The single write port is synchronous. A dedicated port reads and writes the saved status register of the current mode. A second path loads the saved status register of any chosen mode, as exception entry logic would. An unlisted mode encoding raises an error output, and all accesses then use the user-mode bank.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low reset every stored register is zero, so every read port, the saved-status read and the current-status output return 0, in every mode.
- R2: Indices 0 to 7 and index 15 name one physical register each, shared by all modes. A write in any mode is seen through that index in every other mode.
- R3: Indices 8 to 12 have a second copy used only in fast-interrupt mode (5'b10001). All other modes, including illegal ones, use the base copy. A write in one copy leaves the other unchanged.
- R4: Indices 13 and 14 have private copies for fast-interrupt (5'b10001), interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes. User (5'b10000) and system (5'b11111) modes share the base copy.
- R5: Both read ports are combinational, and the two return the same value for the same index. A write takes effect at the rising clock edge. A read of the register being written in that same cycle returns the old value.
- R6: The saved-status port reads and writes the copy that belongs to the current mode. Each of the five exception modes has its own copy.
- R7: In user or system mode the saved-status read returns 0, and a saved-status write changes no stored copy.
- R8: The load path writes the saved status register of the mode given on its own mode input. A target of user, system or an illegal code is ignored. When the load and the current-mode saved-status write hit the same copy in one cycle, the current-mode write wins.
- R9: A mode input outside the seven legal codes drives `mode_err_o` high, and all general and saved-status accesses behave as in user mode. A legal code keeps `mode_err_o` low.
- R10: The current status register is written through its own enable, is visible on `cur_sr_o` from the next cycle, and does not depend on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| mode_err_o | output | 1 | High when mode_i is not a legal code |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Write architectural index |
| wr_data_i | input | 32 | Write data |
| sr_rd_data_o | output | 32 | Saved status register of the current mode |
| sr_wr_en_i | input | 1 | Write enable for the current mode's saved status |
| sr_wr_data_i | input | 32 | Saved status write data |
| ld_en_i | input | 1 | Load enable for a chosen mode's saved status |
| ld_mode_i | input | 5 | Mode whose saved status is loaded |
| ld_data_i | input | 32 | Load data |
| cur_sr_wr_en_i | input | 1 | Current status register write enable |
| cur_sr_wr_data_i | input | 32 | Current status register write data |
| cur_sr_o | output | 32 | Current status register value |

## Verification
The bench aims at banking leaks. It writes one index in one mode and reads it in a mode that banks it and in one that shares it. A design that maps index 12 or index 13 wrongly returns the other mode's value there. Same-cycle write and read of one register is driven on purpose, and a design that forwards write data would show the new value one cycle early. Load and current-mode writes are made to collide on one saved copy, and saved-status accesses are tried in user, system and illegal modes. A design with the wrong priority, or with a writable saved copy in user mode, would return the wrong value on the saved-status read.

// File: rtl/banked_rf_pkg.sv
// Package: shared types and constants of the mode-banked register file.
// Assumes a 5-bit mode code and 16 architectural indices.
package banked_rf_pkg;

    // Legal mode codes
    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // Register bank selected by a mode; the order fixes the saved-status slot (bank - 1)
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    localparam int ARCH_REGS   = 16;               // architectural indices
    localparam int FIQ_LO      = 8;                // first index with a fast-interrupt copy
    localparam int FIQ_HI      = 12;               // last index with a fast-interrupt copy
    localparam int FIQ_COPIES  = FIQ_HI - FIQ_LO + 1;
    localparam int SP_IDX      = 13;               // stack slot
    localparam int LR_IDX      = 14;               // link slot
    localparam int EXC_BANKS   = 5;                // modes with private stack/link/saved status
    localparam int PHYS_GPR    = ARCH_REGS + FIQ_COPIES + 2 * EXC_BANKS;
    localparam int PHYS_W      = $clog2(PHYS_GPR);

endpackage

// File: rtl/mode_decode.sv
// Module: mode_decode
// Turns a 5-bit mode code into the bank it selects and a legality flag.
// Assumes nothing about the code; unlisted codes fall back to the user bank.
module mode_decode
    import banked_rf_pkg::*;
(
    input  logic [4:0] mode_i,
    output bank_e      bank_o,
    output logic       legal_o
);

    // Map every code onto a bank, flagging the unlisted ones
    always_comb begin
        legal_o = 1'b1;
        case (mode_i)
            MODE_USR, MODE_SYS: bank_o = BANK_USR;
            MODE_FIQ:           bank_o = BANK_FIQ;
            MODE_IRQ:           bank_o = BANK_IRQ;
            MODE_SVC:           bank_o = BANK_SVC;
            MODE_ABT:           bank_o = BANK_ABT;
            MODE_UND:           bank_o = BANK_UND;
            default: begin
                bank_o  = BANK_USR;
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bank_map.sv
// Module: bank_map
// Computes the physical general-register slot for an architectural index in a bank.
// Layout: 0..15 base copy, then the fast-interrupt copies of 8..12, then one
// stack/link pair per exception bank in bank order.
module bank_map
    import banked_rf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  bank_e             bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PHYS_W-1:0] phys_o
);

    localparam int PAIR_BASE = ARCH_REGS + FIQ_COPIES;

    logic is_fiq_range;
    logic is_pair;

    // Classify the index against the banked ranges
    always_comb begin
        is_fiq_range = (int'(idx_i) >= FIQ_LO) && (int'(idx_i) <= FIQ_HI);
        is_pair      = (int'(idx_i) == SP_IDX) || (int'(idx_i) == LR_IDX);
    end

    // Pick the slot: private pair, fast-interrupt copy or base copy
    always_comb begin
        if (is_pair && (bank_i != BANK_USR)) begin
            phys_o = PHYS_W'(PAIR_BASE + 2 * (int'(bank_i) - 1) + (int'(idx_i) - SP_IDX));
        end else if (is_fiq_range && (bank_i == BANK_FIQ)) begin
            phys_o = PHYS_W'(ARCH_REGS + (int'(idx_i) - FIQ_LO));
        end else begin
            phys_o = PHYS_W'(idx_i);
        end
    end

endmodule

// File: rtl/gpr_array.sv
// Module: gpr_array
// Flat storage of the physical general registers: one synchronous write port,
// two combinational read ports addressed by physical slot. Reads see the
// value held before a same-cycle write.
module gpr_array
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_REGS = PHYS_GPR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PHYS_W-1:0] wslot_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PHYS_W-1:0] rslot_a_i,
    input  logic [PHYS_W-1:0] rslot_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);

    logic [DATA_W-1:0] regs_q [N_REGS];

    // Clear on reset, else store the write data in the addressed slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
        end else if (we_i) begin
            for (int i = 0; i < N_REGS; i++) begin
                if (int'(wslot_i) == i) regs_q[i] <= wdata_i;
            end
        end
    end

    // Read both ports straight from the stored values
    always_comb begin
        rdata_a_o = '0;
        rdata_b_o = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (int'(rslot_a_i) == i) rdata_a_o = regs_q[i];
            if (int'(rslot_b_i) == i) rdata_b_o = regs_q[i];
        end
    end

endmodule

// File: rtl/status_bank.sv
// Module: status_bank
// Holds the current status register and one saved status register per
// exception bank. The current-mode port outranks the load path on a clash.
// Assumes the user bank (also used for illegal codes) owns no saved copy.
module status_bank
    import banked_rf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_SAVED = EXC_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank_i,
    input  logic              cur_we_i,
    input  logic [DATA_W-1:0] cur_wdata_i,
    output logic [DATA_W-1:0] cur_rdata_o,
    input  bank_e             ld_bank_i,
    input  logic              ld_we_i,
    input  logic [DATA_W-1:0] ld_wdata_i,
    input  logic              cs_we_i,
    input  logic [DATA_W-1:0] cs_wdata_i,
    output logic [DATA_W-1:0] cs_o
);

    logic [DATA_W-1:0] saved_q [N_SAVED];
    logic [DATA_W-1:0] cs_q;
    logic [N_SAVED-1:0] hit_cur;
    logic [N_SAVED-1:0] hit_ld;

    // One saved copy per exception bank, each with its own write selection
    for (genvar g = 0; g < N_SAVED; g++) begin : g_saved
        assign hit_cur[g] = cur_we_i && (int'(cur_bank_i) == g + 1);
        assign hit_ld[g]  = ld_we_i  && (int'(ld_bank_i)  == g + 1);

        // Update copy g; the current-mode write takes precedence over the load
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          saved_q[g] <= '0;
            else if (hit_cur[g]) saved_q[g] <= cur_wdata_i;
            else if (hit_ld[g])  saved_q[g] <= ld_wdata_i;
        end
    end

    // Present the current bank's copy, or zero for the user bank
    always_comb begin
        cur_rdata_o = '0;
        for (int i = 0; i < N_SAVED; i++) begin
            if (int'(cur_bank_i) == i + 1) cur_rdata_o = saved_q[i];
        end
    end

    // Current status register, independent of the mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cs_q <= '0;
        else if (cs_we_i) cs_q <= cs_wdata_i;
    end

    assign cs_o = cs_q;

endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Mode-banked register file: decodes the current and load modes, maps each
// architectural index to its physical slot and drives the general and status
// storage. Assumes the mode input is stable for the whole cycle.
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    output logic              mode_err_o,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] sr_rd_data_o,
    input  logic              sr_wr_en_i,
    input  logic [DATA_W-1:0] sr_wr_data_i,
    input  logic              ld_en_i,
    input  logic [4:0]        ld_mode_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              cur_sr_wr_en_i,
    input  logic [DATA_W-1:0] cur_sr_wr_data_i,
    output logic [DATA_W-1:0] cur_sr_o
);

    localparam int N_PORTS = 3;   // read A, read B, write

    bank_e             cur_bank;
    bank_e             ld_bank;
    logic              cur_legal;
    logic              ld_legal;
    logic [IDX_W-1:0]  port_idx  [N_PORTS];
    logic [PHYS_W-1:0] port_slot [N_PORTS];

    // Current mode decode
    mode_decode u_cur_dec (
        .mode_i  (mode_i),
        .bank_o  (cur_bank),
        .legal_o (cur_legal)
    );

    // Load target decode; an illegal target lands on the user bank and is dropped
    mode_decode u_ld_dec (
        .mode_i  (ld_mode_i),
        .bank_o  (ld_bank),
        .legal_o (ld_legal)
    );

    assign mode_err_o = !cur_legal;

    assign port_idx[0] = rd_a_idx_i;
    assign port_idx[1] = rd_b_idx_i;
    assign port_idx[2] = wr_idx_i;

    // One slot mapper per access port
    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        bank_map #(.IDX_W(IDX_W)) u_map (
            .bank_i (cur_bank),
            .idx_i  (port_idx[p]),
            .phys_o (port_slot[p])
        );
    end

    // Physical general registers
    gpr_array #(.DATA_W(DATA_W), .N_REGS(PHYS_GPR)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i),
        .wslot_i   (port_slot[2]),
        .wdata_i   (wr_data_i),
        .rslot_a_i (port_slot[0]),
        .rslot_b_i (port_slot[1]),
        .rdata_a_o (rd_a_data_o),
        .rdata_b_o (rd_b_data_o)
    );

    // Status registers; ld_legal is folded into ld_bank by the decoder
    status_bank #(.DATA_W(DATA_W), .N_SAVED(EXC_BANKS)) u_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_bank_i  (cur_bank),
        .cur_we_i    (sr_wr_en_i),
        .cur_wdata_i (sr_wr_data_i),
        .cur_rdata_o (sr_rd_data_o),
        .ld_bank_i   (ld_bank),
        .ld_we_i     (ld_en_i && ld_legal),
        .ld_wdata_i  (ld_data_i),
        .cs_we_i     (cur_sr_wr_en_i),
        .cs_wdata_i  (cur_sr_wr_data_i),
        .cs_o        (cur_sr_o)
    );

endmodule

// File: rtl/banked_regfile_chk.sv
// Module: banked_regfile_chk
// Property checker for banked_regfile, attached through bind.
// Keeps its own list of legal and exception mode codes.
module banked_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              mode_err_o,
    input logic [IDX_W-1:0]  rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [IDX_W-1:0]  rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] sr_rd_data_o,
    input logic              sr_wr_en_i,
    input logic [DATA_W-1:0] sr_wr_data_i,
    input logic [DATA_W-1:0] cur_sr_o,
    input logic              cur_sr_wr_en_i,
    input logic [DATA_W-1:0] cur_sr_wr_data_i
);

    logic legal_mode;
    logic exc_mode;
    logic shared_idx;

    // Independent classification of the current mode and write index
    always_comb begin
        exc_mode   = (mode_i == 5'b10001) || (mode_i == 5'b10010) || (mode_i == 5'b10011) ||
                     (mode_i == 5'b10111) || (mode_i == 5'b11011);
        legal_mode = exc_mode || (mode_i == 5'b10000) || (mode_i == 5'b11111);
        shared_idx = (wr_idx_i < 4'd8) || (wr_idx_i == 4'd15);
    end

    // R2
    shared_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && shared_idx) |=>
        ((rd_a_idx_i != $past(wr_idx_i)) || (rd_a_data_o == $past(wr_data_i))));

    // R5
    write_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=>
        ((mode_i != $past(mode_i)) || (rd_b_idx_i != $past(wr_idx_i)) ||
         (rd_b_data_o == $past(wr_data_i))));

    // R5
    ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));

    // R6
    saved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en_i && exc_mode) |=>
        ((mode_i != $past(mode_i)) || (sr_rd_data_o == $past(sr_wr_data_i))));

    // R7
    saved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> (sr_rd_data_o == '0));

    // R9
    mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o != legal_mode);

    // R10
    cur_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_sr_wr_en_i |=> (cur_sr_o == $past(cur_sr_wr_data_i)));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
// Bench for banked_regfile: a behavioural reference model, compared at every
// falling edge; directed phases per requirement followed by random traffic.
module tb_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic        mode_err;
    logic [3:0]  ra = '0, rb = '0, wi = '0;
    logic [31:0] rda, rdb, wd = '0;
    logic        we = 1'b0;
    logic [31:0] srd, swd = '0;
    logic        swe = 1'b0;
    logic        lde = 1'b0;
    logic [4:0]  ldm = 5'b10000;
    logic [31:0] ldd = '0;
    logic        cwe = 1'b0;
    logic [31:0] cwd = '0, cso;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";

    // Reference state indexed by index or by mode code
    logic [31:0] m_base [16];
    logic [31:0] m_fiq  [16];
    logic [31:0] m_sp   [32];
    logic [31:0] m_lr   [32];
    logic [31:0] m_sr   [32];
    logic [31:0] m_cs;

    localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111};

    always #2 clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .mode_err_o(mode_err),
        .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
        .sr_rd_data_o(srd), .sr_wr_en_i(swe), .sr_wr_data_i(swd),
        .ld_en_i(lde), .ld_mode_i(ldm), .ld_data_i(ldd),
        .cur_sr_wr_en_i(cwe), .cur_sr_wr_data_i(cwd), .cur_sr_o(cso)
    );

    function automatic bit is_legal(logic [4:0] m);
        foreach (MODES[i]) if (MODES[i] == m) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit is_exc(logic [4:0] m);
        return is_legal(m) && (m != 5'b10000) && (m != 5'b11111);
    endfunction

    function automatic logic [4:0] eff(logic [4:0] m);
        return is_legal(m) ? m : 5'b10000;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] m, int idx);
        logic [4:0] e = eff(m);
        if (idx >= 8 && idx <= 12 && e == 5'b10001) return m_fiq[idx];
        if ((idx == 13 || idx == 14) && is_exc(e)) return (idx == 13) ? m_sp[e] : m_lr[e];
        return m_base[idx];
    endfunction

    task automatic m_write(logic [4:0] m, int idx, logic [31:0] v);
        logic [4:0] e = eff(m);
        if (idx >= 8 && idx <= 12 && e == 5'b10001) m_fiq[idx] = v;
        else if ((idx == 13 || idx == 14) && is_exc(e)) begin
            if (idx == 13) m_sp[e] = v; else m_lr[e] = v;
        end else m_base[idx] = v;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_fiq[i] = '0; end
        for (int i = 0; i < 32; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sr[i] = '0; end
        m_cs = '0;
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s mode=%b actual=%h expected=%h", tag, what, mode, act, exp);
        end
    endtask

    // One cycle: compare at the falling edge, update the model at the rising edge
    task automatic step();
        @(negedge clk);
        check("rd_a", rda, m_read(mode, int'(ra)));
        check("rd_b", rdb, m_read(mode, int'(rb)));
        check("sr_rd", srd, is_exc(eff(mode)) ? m_sr[eff(mode)] : 32'h0);
        check("cur_sr", cso, m_cs);
        check("mode_err", {31'h0, mode_err}, {31'h0, !is_legal(mode)});
        @(posedge clk);
        if (lde && is_exc(ldm)) m_sr[ldm] = ldd;
        if (swe && is_exc(eff(mode))) m_sr[eff(mode)] = swd;
        if (cwe) m_cs = cwd;
        if (we) m_write(mode, int'(wi), wd);
        #1;
    endtask

    task automatic quiet();
        we = 1'b0; swe = 1'b0; lde = 1'b0; cwe = 1'b0;
    endtask

    task automatic wr(logic [4:0] m, int idx, logic [31:0] v);
        mode = m; we = 1'b1; wi = 4'(idx); wd = v; ra = 4'(idx); rb = 4'(idx);
        step();
        quiet();
    endtask

    task automatic sweep(logic [4:0] m);
        mode = m;
        for (int i = 0; i < 16; i++) begin ra = 4'(i); rb = 4'(15 - i); step(); end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: all zero after reset, in every mode
        tag = "R1";
        foreach (MODES[k]) sweep(MODES[k]);

        // R2: shared low registers and index 15
        tag = "R2";
        for (int i = 0; i < 8; i++) wr(5'b10010, i, 32'hA000_0000 + i);
        wr(5'b10001, 15, 32'hF00D_0015);
        sweep(5'b10000);
        sweep(5'b10001);

        // R3: fast-interrupt copy of 8..12
        tag = "R3";
        for (int i = 8; i <= 12; i++) wr(5'b10000, i, 32'hB000_0000 + i);
        for (int i = 8; i <= 12; i++) wr(5'b10001, i, 32'hC000_0000 + i);
        sweep(5'b11111);
        sweep(5'b10001);
        sweep(5'b10011);

        // R4: stack and link per exception mode
        tag = "R4";
        foreach (MODES[k]) begin
            wr(MODES[k], 13, 32'hD000_0000 + k);
            wr(MODES[k], 14, 32'hE000_0000 + k);
        end
        foreach (MODES[k]) sweep(MODES[k]);

        // R5: same-cycle read sees the old value, then the new one
        tag = "R5";
        mode = 5'b10111; we = 1'b1; wi = 4'd13; wd = 32'h5555_AAAA; ra = 4'd13; rb = 4'd13;
        step();
        quiet();
        step();
        mode = 5'b10000; we = 1'b1; wi = 4'd3; wd = 32'h1234_5678; ra = 4'd3; rb = 4'd9;
        step();
        quiet();
        step();

        // R6: saved status per exception mode
        tag = "R6";
        foreach (MODES[k]) begin
            mode = MODES[k]; swe = 1'b1; swd = 32'h6600_0000 + k;
            step();
            quiet();
        end
        foreach (MODES[k]) begin mode = MODES[k]; step(); end

        // R7: user and system have no saved copy
        tag = "R7";
        mode = 5'b10000; swe = 1'b1; swd = 32'h7777_7777; step();
        mode = 5'b11111; swd = 32'h7171_7171; step();
        quiet();
        foreach (MODES[k]) begin mode = MODES[k]; step(); end

        // R8: load path, ignored targets, and collision priority
        tag = "R8";
        mode = 5'b10000;
        foreach (MODES[k]) begin
            lde = 1'b1; ldm = MODES[k]; ldd = 32'h8800_0000 + k;
            step();
        end
        ldm = 5'b00101; ldd = 32'hDEAD_BEEF; step();
        mode = 5'b10010; lde = 1'b1; ldm = 5'b10010; ldd = 32'h1111_1111;
        swe = 1'b1; swd = 32'h2222_2222;
        step();
        quiet();
        foreach (MODES[k]) begin mode = MODES[k]; step(); end

        // R9: illegal codes flag and use the user bank
        tag = "R9";
        wr(5'b00000, 13, 32'h9999_0013);
        wr(5'b10100, 9, 32'h9999_0009);
        mode = 5'b01111; swe = 1'b1; swd = 32'h9090_9090; step();
        quiet();
        sweep(5'b10000);
        sweep(5'b10001);
        mode = 5'b10011; step();

        // R10: current status register
        tag = "R10";
        mode = 5'b10001; cwe = 1'b1; cwd = 32'hC5C5_0001; step();
        cwe = 1'b0; mode = 5'b00011; step();
        mode = 5'b10000; step();

        // R5: random traffic across all paths
        tag = "R5";
        for (int n = 0; n < 3000; n++) begin
            mode = ($urandom_range(0, 15) == 0) ? 5'($urandom) : MODES[$urandom_range(0, 6)];
            ra = 4'($urandom); rb = 4'($urandom);
            we = 1'($urandom); wi = 4'($urandom); wd = $urandom;
            swe = ($urandom_range(0, 3) == 0); swd = $urandom;
            lde = ($urandom_range(0, 3) == 0);
            ldm = ($urandom_range(0, 7) == 0) ? 5'($urandom) : MODES[$urandom_range(0, 6)];
            ldd = $urandom;
            cwe = ($urandom_range(0, 3) == 0); cwd = $urandom;
            step();
        end
        quiet();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule